// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Controller

This block chooses which of fifteen interrupt sources the processor core should service next. Every source has its own enable bit, and one global enable gates them all. Each source also has a two-bit priority level, built from one bit in a low-priority vector and one bit in a high-priority vector. The block records which levels are currently in service. A new request is offered only if its level is strictly above the level that is running now.

Decisions are taken only when the core signals an instruction boundary. The winner is presented as a request flag and a source index. It stays on the outputs until the core acknowledges it with a one-cycle pulse. When a service routine ends, the core sends an end-of-service pulse, and the innermost in-service level is released.

Sources 0 and 1 come from two active-low external pins. Each pin has a mode bit that selects level or falling-edge detection. Sources 2 to 14 are internal request lines that are active high.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, `irq_req` is low and `svc_mask` is 0000.
- R2: While `glob_en` is low, no new request is raised, whatever the other inputs are.
- R3: A source whose `src_en` bit is clear never wins arbitration, even if its level is higher than every other pending source.
- R4: The level of source i is {`lvl_hi[i]`,`lvl_lo[i]`}, from 0 to 3. Among eligible pending sources, one with the highest level is chosen.
- R5: When several eligible sources share the highest level, the one with the lowest index wins.
- R6: `svc_mask` bit n set means level n is in service. The running level is the highest set bit. A candidate is offered only if `svc_mask` is zero or the candidate's level is strictly greater than the running level. Same or lower levels wait.
- R7: While `svc_mask[3]` is set, no request is raised.
- R8: A decision is taken only on a clock edge where `insn_bound` is high and `irq_req` is low. The result appears on `irq_req`/`irq_idx` after that edge. It is then held unchanged until acknowledged, whatever the inputs do.
- R9: An `irq_ack` pulse while `irq_req` is high drops `irq_req` at the next edge and sets the `svc_mask` bit of the granted level. An `irq_ack` while `irq_req` is low has no effect.
- R10: An `irq_eos` pulse clears the highest set bit of `svc_mask`.
- R11: Pin `ext_n[k]` drives source k (k = 0, 1). With `ext_edge[k]` = 0 (level mode), source k is pending while the pin, sampled through one register, reads low.
- R12: With `ext_edge[k]` = 1 (edge mode), a sample reading high followed by a sample reading low sets a latch. The latch holds after the pin returns high, keeps source k pending, and is cleared when that source's grant is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_req | input | 13 | Internal request lines; bit j is source j+2 |
| ext_n | input | 2 | Active-low external pins for sources 0 and 1 |
| ext_edge | input | 2 | Per-pin mode: 1 = falling edge, 0 = level |
| glob_en | input | 1 | Global enable |
| src_en | input | 15 | Per-source enable |
| lvl_lo | input | 15 | Low bit of each source's level |
| lvl_hi | input | 15 | High bit of each source's level |
| insn_bound | input | 1 | Instruction-boundary strobe |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_eos | input | 1 | Core finished the innermost routine |
| irq_req | output | 1 | Request to the core |
| irq_idx | output | 4 | Index of the requesting source |
| svc_mask | output | 4 | One in-service bit per level |

## Verification
The hardest situation to reach is a nested state, where lower levels are still in service while a higher one is offered, and then the stack unwinding one level at a time. The stimulus builds it on purpose. It grants and acknowledges a level-0 source, shows that an equal-level request is held back, raises a level-1 request that preempts, and then issues end-of-service pulses one by one. After each pulse it checks which pending request becomes eligible. A second sequence fills level 3 and shows that level-3 and level-2 requests both stay blocked until that level is released. The edge latch is reached by pulsing a pin low for two cycles and restoring it well before the boundary strobe.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int NSRC = 15;
    localparam int NEXT = 2;
    localparam int NLVL = 4;
    localparam int NINT = NSRC - NEXT;
    localparam int IDXW = $clog2(NSRC);
    localparam int LVLW = $clog2(NLVL);

    typedef logic [IDXW-1:0] idx_t;
    typedef logic [LVLW-1:0] lvl_t;

    typedef struct packed {
        logic vld;
        idx_t idx;
        lvl_t lvl;
    } grant_t;

    typedef struct packed {
        logic busy;
        lvl_t lvl;
    } run_t;

    function automatic idx_t lowest_idx(input logic [NSRC-1:0] v);
        idx_t r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = idx_t'(i);
        end
        return r;
    endfunction

    function automatic lvl_t top_level(input logic [NLVL-1:0] m);
        lvl_t r;
        r = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (m[i]) r = lvl_t'(i);
        end
        return r;
    endfunction

    function automatic logic [NLVL-1:0] top_bit(input logic [NLVL-1:0] m);
        logic [NLVL-1:0] r;
        r = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (m[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pirq_ext_detect.sv
module pirq_ext_detect
    import pirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NEXT-1:0] pin_n,
    input  logic [NEXT-1:0] edge_mode,
    input  logic [NEXT-1:0] clr,
    output logic [NEXT-1:0] pend
);

    for (genvar e = 0; e < NEXT; e++) begin : g_ch
        logic samp_q;
        logic samp_qq;
        logic latch_q;
        logic fall;

        assign fall = samp_qq & ~samp_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                samp_q  <= 1'b1;
                samp_qq <= 1'b1;
                latch_q <= 1'b0;
            end else begin
                samp_q  <= pin_n[e];
                samp_qq <= samp_q;
                if (!edge_mode[e])
                    latch_q <= 1'b0;
                else if (fall)
                    latch_q <= 1'b1;
                else if (clr[e])
                    latch_q <= 1'b0;
            end
        end

        assign pend[e] = edge_mode[e] ? latch_q : ~samp_q;
    end

endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter
    import pirq_pkg::*;
(
    input  logic [NSRC-1:0] elig,
    input  logic [NSRC-1:0] lvl_lo,
    input  logic [NSRC-1:0] lvl_hi,
    output grant_t          cand
);

    logic [NLVL-1:0][NSRC-1:0] at_lvl;

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            assign at_lvl[l][i] = elig[i] && ({lvl_hi[i], lvl_lo[i]} == lvl_t'(l));
        end
    end

    always_comb begin
        cand = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (|at_lvl[l]) begin
                cand.vld = 1'b1;
                cand.lvl = lvl_t'(l);
                cand.idx = lowest_idx(at_lvl[l]);
            end
        end
    end

endmodule

// File: rtl/pirq_svc_stack.sv
module pirq_svc_stack
    import pirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  lvl_t            push_lvl,
    input  logic            pop,
    output logic [NLVL-1:0] mask,
    output run_t            run
);

    logic [NLVL-1:0] mask_q;
    logic [NLVL-1:0] after_pop;
    logic [NLVL-1:0] push_bit;

    always_comb begin
        after_pop = pop ? (mask_q & ~top_bit(mask_q)) : mask_q;
        push_bit  = '0;
        if (push) push_bit[push_lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= after_pop | push_bit;
    end

    assign mask     = mask_q;
    assign run.busy = |mask_q;
    assign run.lvl  = top_level(mask_q);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NINT-1:0]      int_req,
    input  logic [NEXT-1:0]      ext_n,
    input  logic [NEXT-1:0]      ext_edge,
    input  logic                 glob_en,
    input  logic [NSRC-1:0]      src_en,
    input  logic [NSRC-1:0]      lvl_lo,
    input  logic [NSRC-1:0]      lvl_hi,
    input  logic                 insn_bound,
    input  logic                 irq_ack,
    input  logic                 irq_eos,
    output logic                 irq_req,
    output logic [IDXW-1:0]      irq_idx,
    output logic [NLVL-1:0]      svc_mask
);

    logic [NEXT-1:0] ext_pend;
    logic [NEXT-1:0] ext_clr;
    logic [NSRC-1:0] raw_pend;
    logic [NSRC-1:0] elig;
    grant_t          cand;
    grant_t          gnt_q;
    run_t            run;
    logic            allow;
    logic            ack_ok;
    lvl_t            gnt_lvl;

    assign ack_ok = gnt_q.vld & irq_ack;

    for (genvar e = 0; e < NEXT; e++) begin : g_clr
        assign ext_clr[e] = ack_ok && (gnt_q.idx == idx_t'(e));
    end

    pirq_ext_detect u_ext (
        .clk       (clk),
        .rst       (rst),
        .pin_n     (ext_n),
        .edge_mode (ext_edge),
        .clr       (ext_clr),
        .pend      (ext_pend)
    );

    assign raw_pend = {int_req, ext_pend};
    assign elig     = raw_pend & src_en & {NSRC{glob_en}};

    pirq_arbiter u_arb (
        .elig   (elig),
        .lvl_lo (lvl_lo),
        .lvl_hi (lvl_hi),
        .cand   (cand)
    );

    pirq_svc_stack u_stk (
        .clk      (clk),
        .rst      (rst),
        .push     (ack_ok),
        .push_lvl (gnt_q.lvl),
        .pop      (irq_eos),
        .mask     (svc_mask),
        .run      (run)
    );

    assign allow = cand.vld && (!run.busy || (cand.lvl > run.lvl));

    always_ff @(posedge clk) begin
        if (rst)
            gnt_q <= '0;
        else if (ack_ok)
            gnt_q.vld <= 1'b0;
        else if (!gnt_q.vld && insn_bound && allow)
            gnt_q <= cand;
    end

    assign irq_req = gnt_q.vld;
    assign irq_idx = gnt_q.idx;
    assign gnt_lvl = gnt_q.lvl;

endmodule

// File: rtl/pirq_chk.sv
module pirq_chk
    import pirq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            irq_req,
    input logic [IDXW-1:0] irq_idx,
    input logic            irq_ack,
    input logic            irq_eos,
    input logic            insn_bound,
    input logic            glob_en,
    input logic [NLVL-1:0] svc_mask,
    input lvl_t            gnt_lvl
);

    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        irq_req && !irq_ack |=> irq_req && $stable(irq_idx));

    a_r8_only_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !irq_req && !insn_bound |=> !irq_req);

    a_r9_ack_drops_req: assert property (@(posedge clk) disable iff (rst)
        irq_req && irq_ack |=> !irq_req);

    a_r9_ack_marks_level: assert property (@(posedge clk) disable iff (rst)
        irq_req && irq_ack && !irq_eos |=> svc_mask[$past(gnt_lvl)]);

    a_r2_global_off: assert property (@(posedge clk) disable iff (rst)
        !irq_req && !glob_en |=> !irq_req);

    a_r7_top_level_blocks: assert property (@(posedge clk) disable iff (rst)
        !irq_req && svc_mask[NLVL-1] |=> !irq_req);

    a_r10_eos_pops_one: assert property (@(posedge clk) disable iff (rst)
        irq_eos && !(irq_req && irq_ack) && (svc_mask != '0)
        |=> $countones(svc_mask) + 1 == $countones($past(svc_mask)));

    a_r4_index_in_range: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> irq_idx < IDXW'(NSRC));

endmodule

bind prio_irq_ctrl pirq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_req    (irq_req),
    .irq_idx    (irq_idx),
    .irq_ack    (irq_ack),
    .irq_eos    (irq_eos),
    .insn_bound (insn_bound),
    .glob_en    (glob_en),
    .svc_mask   (svc_mask),
    .gnt_lvl    (gnt_lvl)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
    import pirq_pkg::*;

    logic            clk = 1'b0;
    logic            rst;
    logic [NINT-1:0] int_req;
    logic [NEXT-1:0] ext_n;
    logic [NEXT-1:0] ext_edge;
    logic            glob_en;
    logic [NSRC-1:0] src_en;
    logic [NSRC-1:0] lvl_lo;
    logic [NSRC-1:0] lvl_hi;
    logic            insn_bound;
    logic            irq_ack;
    logic            irq_eos;
    logic            irq_req;
    logic [IDXW-1:0] irq_idx;
    logic [NLVL-1:0] svc_mask;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl dut (
        .clk(clk), .rst(rst), .int_req(int_req), .ext_n(ext_n),
        .ext_edge(ext_edge), .glob_en(glob_en), .src_en(src_en),
        .lvl_lo(lvl_lo), .lvl_hi(lvl_hi), .insn_bound(insn_bound),
        .irq_ack(irq_ack), .irq_eos(irq_eos), .irq_req(irq_req),
        .irq_idx(irq_idx), .svc_mask(svc_mask)
    );

    typedef struct packed {
        logic [14:0] en;
        logic [14:0] lo;
        logic [14:0] hi;
        logic [14:0] req;
        logic        ev;
        logic [3:0]  ei;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{15'h7FFF, 15'h0000, 15'h0000, 15'h0020, 1'b1, 4'd5},   // R4 single
        '{15'h7FFF, 15'h0000, 15'h0000, 15'h0220, 1'b1, 4'd5},   // R5 tie
        '{15'h7FFF, 15'h0000, 15'h0200, 15'h0220, 1'b1, 4'd9},   // R4 level 2 wins
        '{15'h7FFF, 15'h1020, 15'h0000, 15'h1220, 1'b1, 4'd5},   // R5 tie at level 1
        '{15'h7FFF, 15'h4000, 15'h4000, 15'h4008, 1'b1, 4'd14},  // R4 level 3
        '{15'h7F7F, 15'h0000, 15'h0000, 15'h0080, 1'b0, 4'd0},   // R3 disabled
        '{15'h7F7F, 15'h0080, 15'h0080, 15'h0180, 1'b1, 4'd8},   // R3 masked high level
        '{15'h7FFF, 15'h0000, 15'h0000, 15'h0000, 1'b0, 4'd0},   // R4 nothing pending
        '{15'h7FFF, 15'h0800, 15'h0C00, 15'h0C00, 1'b1, 4'd11}   // R4 level 3 over 2
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_req(input logic [14:0] v);
        int_req = v[14:2];
    endtask

    task automatic boundary();
        insn_bound = 1'b1;
        tick(1);
        insn_bound = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
    endtask

    task automatic eos();
        irq_eos = 1'b1;
        tick(1);
        irq_eos = 1'b0;
    endtask

    task automatic quiet();
        int_req = '0;
        lvl_lo  = '0;
        lvl_hi  = '0;
        src_en  = '1;
        glob_en = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; int_req = '0; ext_n = '1; ext_edge = '0; glob_en = 1'b0;
        src_en = '0; lvl_lo = '0; lvl_hi = '0; insn_bound = 1'b0;
        irq_ack = 1'b0; irq_eos = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(1);
        check("R1 req", irq_req, 0);
        check("R1 mask", svc_mask, 0);

        for (int k = 0; k < NV; k++) begin
            src_en = TBL[k].en; lvl_lo = TBL[k].lo; lvl_hi = TBL[k].hi;
            glob_en = 1'b1;
            set_req(TBL[k].req);
            tick(1);
            boundary();
            check($sformatf("R4/R5 row %0d req", k), irq_req, TBL[k].ev);
            if (TBL[k].ev) begin
                check($sformatf("R4/R5 row %0d idx", k), irq_idx, TBL[k].ei);
                ack();
                eos();
            end
            check($sformatf("R10 row %0d mask", k), svc_mask, 0);
        end

        // R2: global enable low
        quiet(); glob_en = 1'b0; set_req(15'h0020); tick(1);
        boundary();
        check("R2 req", irq_req, 0);

        // R8: no decision without boundary, then hold
        quiet(); set_req(15'h0010); tick(3);
        check("R8 no boundary", irq_req, 0);
        boundary();
        check("R8 req", irq_req, 1);
        check("R8 idx", irq_idx, 4);
        set_req(15'h0008); lvl_hi = '1; tick(3);
        check("R8 held req", irq_req, 1);
        check("R8 held idx", irq_idx, 4);
        lvl_hi = '0;
        ack();
        check("R9 req drop", irq_req, 0);
        check("R9 mask", svc_mask, 4'b0001);

        // R6: nesting
        set_req(15'h0040); tick(1);
        boundary();
        check("R6 equal level waits", irq_req, 0);
        lvl_lo[6] = 1'b1; tick(1);
        boundary();
        check("R6 preempt req", irq_req, 1);
        check("R6 preempt idx", irq_idx, 6);
        ack();
        check("R9 nested mask", svc_mask, 4'b0011);
        set_req(15'h0008); lvl_lo = '0; lvl_lo[3] = 1'b1; tick(1);
        boundary();
        check("R6 same level blocked", irq_req, 0);
        eos();
        check("R10 pop to 0001", svc_mask, 4'b0001);
        boundary();
        check("R6 after pop idx", irq_idx, 3);
        check("R6 after pop req", irq_req, 1);
        ack();
        eos();
        eos();
        check("R10 empty", svc_mask, 0);

        // R7: level 3 blocks everything
        quiet(); set_req(15'h2000); lvl_lo[13] = 1'b1; lvl_hi[13] = 1'b1; tick(1);
        boundary(); ack();
        check("R7 mask", svc_mask, 4'b1000);
        set_req(15'h1004); lvl_lo = 15'h0004; lvl_hi = 15'h1004; tick(1);
        boundary();
        check("R7 blocked", irq_req, 0);
        eos();
        boundary();
        check("R7 released idx", irq_idx, 2);
        ack(); eos();
        quiet();

        // R9: stray ack
        ack();
        check("R9 stray ack mask", svc_mask, 0);

        // R11: level mode pin 1
        ext_edge = 2'b00; ext_n = 2'b01; tick(2);
        boundary();
        check("R11 req", irq_req, 1);
        check("R11 idx", irq_idx, 1);
        ack(); eos();
        ext_n = 2'b11; tick(2);
        boundary();
        check("R11 released", irq_req, 0);

        // R12: edge mode pin 0
        ext_edge = 2'b01; tick(2);
        boundary();
        check("R12 idle", irq_req, 0);
        ext_n = 2'b10; tick(2);
        ext_n = 2'b11; tick(3);
        boundary();
        check("R12 latched req", irq_req, 1);
        check("R12 latched idx", irq_idx, 0);
        ack(); eos();
        tick(1);
        boundary();
        check("R12 cleared", irq_req, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule